// File: doc/BRIEF.md
# Word FIFO pair with self-clearing flush for a byte-serial bus engine

This block sits between a simple register bus and a byte-oriented serial engine. Software pushes 32-bit words into a transmit FIFO and pops 32-bit words from a receive FIFO. On the engine side, a transmit unpacker offers the bytes of each word one at a time, lowest byte lane first. A receive packer gathers incoming bytes into words in the same lane order. A transfer whose length is not a multiple of four ends in a short word. On transmit, the engine marks the final byte it accepts, and the rest of that word is discarded. On receive, the engine marks the final byte, and the partial word is closed with its unused upper lanes zero.

A control register holds two trigger levels and two flush bits. The trigger levels set when the transmit and receive data-request outputs are raised. Writing a 1 to a flush bit empties that FIFO. The bit then reads back as 1 until the flush is done and clears by itself, so software polls it. A status register reports the free transmit slots and the filled receive words. A push into a full transmit FIFO raises an overflow pulse. A pop from an empty receive FIFO returns zero and raises an underflow pulse. The block produces no serial line signalling itself.

Top module: `i2c_word_fifo`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x80 (8 free, 0 filled), no transmit byte is offered, the transmit request is high, the receive request is low, and both error pulses are low.
- R2: The register map is: address 0 control, 1 status, 2 transmit data (write pushes), 3 receive data (read pops). A pushed word is offered to the engine as bytes 7:0, 15:8, 23:16, 31:24 in that order. Each byte is held stable while the engine is not ready.
- R3: When the engine asserts its last flag on an accepted byte, the remaining bytes of that word are dropped. The next byte offered is lane 0 of the next word.
- R4: Received bytes are packed with the first byte in bits 7:0. A word enters the receive FIFO on the edge that accepts its fourth byte.
- R5: A received byte flagged last closes the word early. Lanes above it read as zero.
- R6: In the status register, bits 7:4 give the free transmit slots and bits 3:0 give the filled receive words.
- R7: In the control register, writing 1 to bit 1 starts a transmit flush and writing 1 to bit 0 starts a receive flush. The bit reads 1 on the two cycles after the write and 0 from the third. The FIFO is then empty, and a transmit word held by the unpacker is discarded.
- R8: A receive flush also discards bytes already packed into an unfinished word.
- R9: The transmit trigger level is in control bits 7:5. The transmit request is high while the free slots exceed the trigger level.
- R10: The receive trigger level is in control bits 4:2. The receive request is high while the filled words exceed the trigger level.
- R11: A push into a full transmit FIFO is dropped, and the overflow output is high for exactly the next cycle.
- R12: A pop from an empty receive FIFO returns 0, and the underflow output is high for exactly the next cycle.
- R13: A flush of one FIFO leaves the contents of the other FIFO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| tx_req_o | output | 1 | Transmit data request |
| rx_req_o | output | 1 | Receive data request |
| tx_ovf_o | output | 1 | Transmit overflow pulse |
| rx_unf_o | output | 1 | Receive underflow pulse |
| eng_tx_byte_o | output | 8 | Byte offered to the engine |
| eng_tx_valid_o | output | 1 | Offered byte is valid |
| eng_tx_ready_i | input | 1 | Engine takes the offered byte |
| eng_tx_last_i | input | 1 | Byte taken is the final one of the transfer |
| eng_rx_byte_i | input | 8 | Byte from the engine |
| eng_rx_valid_i | input | 1 | Received byte is valid |
| eng_rx_last_i | input | 1 | Received byte is the final one of the transfer |

## Verification
Control, status and receive-data reads are combinational and are sampled within the access cycle. Overflow and underflow pulses are checked in the cycle after the access edge, and checked low again one cycle later. A flush bit is read on three back-to-back cycles after its write, with expected values 1, 1, 0. After that the status shows the emptied FIFO. Transmit bytes come out two edges after a push into an idle unpacker, so a monitor compares each handshaken byte against a queue of expected bytes. Received words count in status from the cycle after the edge that took their closing byte, and each popped word is compared against a word model kept by the bench.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FIELD_W = 4;   // status count field width
  localparam int unsigned TRIG_W  = 3;
  localparam int unsigned N_CH    = 2;   // flush channels: 0 rx, 1 tx

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

  localparam int unsigned CH_RX = 0;
  localparam int unsigned CH_TX = 1;
endpackage

// File: rtl/wf_fifo.sv
module wf_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/wf_flush_seq.sv
module wf_flush_seq #(
  parameter int unsigned FLUSH_CYC = 2,
  localparam int unsigned FW = $clog2(FLUSH_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pend_o,
  output logic done_o
);
  logic          pend_q;
  logic [FW-1:0] cnt_q;

  // done in the last pending cycle; the FIFO clears on that edge
  assign done_o = pend_q && (cnt_q == FW'(FLUSH_CYC - 1));
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end else if (req_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
#(
  parameter int unsigned FLUSH_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [TRIG_W-1:0] tx_trig_o,
  output logic [TRIG_W-1:0] rx_trig_o,
  output logic [N_CH-1:0]   pend_o,
  output logic [N_CH-1:0]   done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_trig_o <= '0;
      rx_trig_o <= '0;
    end else if (wr_i) begin
      tx_trig_o <= wdata_i[7:5];
      rx_trig_o <= wdata_i[4:2];
    end
  end

  // flush bit position equals channel index (R7)
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_flush
    wf_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) i_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (wr_i & wdata_i[ch]),
      .pend_o (pend_o[ch]),
      .done_o (done_o[ch])
    );
  end
endmodule

// File: rtl/wf_tx_unpack.sv
module wf_tx_unpack
  import wf_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned WW   = BYTES * BYTE_W,
  localparam int unsigned IW   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              avail_i,
  input  logic [WW-1:0]     word_i,
  output logic              pop_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  input  logic              ready_i,
  input  logic              last_i
);
  logic          hold_v_q;
  logic [WW-1:0] hold_w_q;
  logic [IW-1:0] idx_q;

  assign pop_o   = ~hold_v_q & avail_i & ~clr_i;
  assign valid_o = hold_v_q;
  assign byte_o  = hold_w_q[idx_q*BYTE_W +: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_w_q <= '0;
      idx_q    <= '0;
    end else if (clr_i) begin
      hold_v_q <= 1'b0;
      idx_q    <= '0;
    end else if (pop_o) begin
      hold_v_q <= 1'b1;
      hold_w_q <= word_i;
      idx_q    <= '0;
    end else if (hold_v_q && ready_i) begin
      // last byte of transfer drops the rest of the word (R3)
      if (last_i || idx_q == IW'(BYTES - 1)) begin
        hold_v_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q    <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wf_rx_pack.sv
module wf_rx_pack
  import wf_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned WW   = BYTES * BYTE_W,
  localparam int unsigned IW   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  output logic              push_o,
  output logic [WW-1:0]     word_o
);
  logic [WW-1:0] acc_q;
  logic [IW-1:0] idx_q;
  logic          close;

  assign close  = valid_i & (last_i | (idx_q == IW'(BYTES - 1)));
  assign push_o = close & ~clr_i;

  // lanes below idx from the accumulator, lane idx from the input, rest zero (R5)
  always_comb begin
    word_o = '0;
    for (int l = 0; l < BYTES; l++) begin
      if (IW'(l) < idx_q)       word_o[l*BYTE_W +: BYTE_W] = acc_q[l*BYTE_W +: BYTE_W];
      else if (IW'(l) == idx_q) word_o[l*BYTE_W +: BYTE_W] = byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (valid_i) begin
      if (close) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q[idx_q*BYTE_W +: BYTE_W] <= byte_i;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_word_fifo.sv
module i2c_word_fifo
  import wf_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned BYTES     = 4,
  parameter int unsigned FLUSH_CYC = 2,
  localparam int unsigned WW       = BYTES * BYTE_W,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [WW-1:0]     bus_wdata_i,
  output logic [WW-1:0]     bus_rdata_o,
  output logic              tx_req_o,
  output logic              rx_req_o,
  output logic              tx_ovf_o,
  output logic              rx_unf_o,
  output logic [BYTE_W-1:0] eng_tx_byte_o,
  output logic              eng_tx_valid_o,
  input  logic              eng_tx_ready_i,
  input  logic              eng_tx_last_i,
  input  logic [BYTE_W-1:0] eng_rx_byte_i,
  input  logic              eng_rx_valid_i,
  input  logic              eng_rx_last_i
);
  reg_sel_e          sel;
  logic              ctrl_wr, tx_wr, rx_rd;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic [N_CH-1:0]   pend, done;
  logic              tx_pend, rx_pend;

  logic [WW-1:0]     tx_word, rx_word, pk_word;
  logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              up_pop, pk_push;
  logic              tx_ovf_q, rx_unf_q;
  logic [FIELD_W-1:0] free_f, fill_f;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign ctrl_wr = bus_valid_i &  bus_write_i & (sel == REG_CTRL);
  assign tx_wr   = bus_valid_i &  bus_write_i & (sel == REG_TXD);
  assign rx_rd   = bus_valid_i & ~bus_write_i & (sel == REG_RXD);
  assign tx_pend = pend[CH_TX];
  assign rx_pend = pend[CH_RX];

  wf_ctrl #(.FLUSH_CYC(FLUSH_CYC)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (bus_wdata_i[7:0]),
    .tx_trig_o (tx_trig),
    .rx_trig_o (rx_trig),
    .pend_o    (pend),
    .done_o    (done)
  );

  wf_fifo #(.DW(WW), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (done[CH_TX]),
    .push_i  (tx_wr & ~tx_full),
    .wdata_i (bus_wdata_i),
    .pop_i   (up_pop),
    .rdata_o (tx_word),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  wf_tx_unpack #(.BYTES(BYTES)) i_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (done[CH_TX]),
    .avail_i (~tx_empty),
    .word_i  (tx_word),
    .pop_o   (up_pop),
    .byte_o  (eng_tx_byte_o),
    .valid_o (eng_tx_valid_o),
    .ready_i (eng_tx_ready_i),
    .last_i  (eng_tx_last_i)
  );

  wf_rx_pack #(.BYTES(BYTES)) i_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (done[CH_RX]),
    .valid_i (eng_rx_valid_i),
    .byte_i  (eng_rx_byte_i),
    .last_i  (eng_rx_last_i),
    .push_o  (pk_push),
    .word_o  (pk_word)
  );

  // words arriving at a full receive FIFO are dropped
  wf_fifo #(.DW(WW), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (done[CH_RX]),
    .push_i  (pk_push & ~rx_full),
    .wdata_i (pk_word),
    .pop_i   (rx_rd),
    .rdata_o (rx_word),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign tx_free  = CW'(DEPTH) - tx_cnt;
  assign free_f   = FIELD_W'(tx_free);
  assign fill_f   = FIELD_W'(rx_cnt);
  assign tx_req_o = tx_free > CW'(tx_trig);   // free >= trig + 1 (R9)
  assign rx_req_o = rx_cnt  > CW'(rx_trig);   // R10

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      case (sel)
        REG_CTRL: bus_rdata_o[7:0] = {tx_trig, rx_trig, tx_pend, rx_pend};
        REG_STAT: bus_rdata_o[7:0] = {free_f, fill_f};
        REG_RXD:  if (!rx_empty) bus_rdata_o = rx_word;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
    end else begin
      tx_ovf_q <= tx_wr & tx_full;
      rx_unf_q <= rx_rd & rx_empty;
    end
  end

  assign tx_ovf_o = tx_ovf_q;
  assign rx_unf_o = rx_unf_q;
endmodule

// File: rtl/wf_checker.sv
module wf_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_wr,
  input logic          rx_rd,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_pend,
  input logic          rx_pend,
  input logic          tx_ovf_o,
  input logic          rx_unf_o,
  input logic [WW-1:0] bus_rdata_o,
  input logic          tx_req_o,
  input logic          rx_req_o,
  input logic          eng_tx_valid_o,
  input logic          eng_tx_ready_i,
  input logic [7:0]    eng_tx_byte_o
);
  a_r11_ovf_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr && tx_cnt == CW'(DEPTH) |=> tx_ovf_o);
  a_r11_no_false_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_wr |=> !tx_ovf_o);
  a_r12_unf_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd && rx_cnt == '0 |-> bus_rdata_o == '0);
  a_r12_unf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd && rx_cnt == '0 |=> rx_unf_o);
  a_r9_req_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt == '0 |-> tx_req_o);
  a_r10_no_req_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt == '0 |-> !rx_req_o);
  a_r7_tx_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_pend) |-> tx_cnt == '0);
  a_r7_rx_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_pend) |-> rx_cnt == '0);
  a_r7_flush_lasts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_pend) |=> tx_pend);
  a_r2_byte_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_tx_valid_o && !eng_tx_ready_i && !tx_pend |=> eng_tx_valid_o && $stable(eng_tx_byte_o));
endmodule

bind i2c_word_fifo wf_checker #(.DEPTH(DEPTH), .WW(WW)) i_wf_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_wr          (tx_wr),
  .rx_rd          (rx_rd),
  .tx_cnt         (tx_cnt),
  .rx_cnt         (rx_cnt),
  .tx_pend        (tx_pend),
  .rx_pend        (rx_pend),
  .tx_ovf_o       (tx_ovf_o),
  .rx_unf_o       (rx_unf_o),
  .bus_rdata_o    (bus_rdata_o),
  .tx_req_o       (tx_req_o),
  .rx_req_o       (rx_req_o),
  .eng_tx_valid_o (eng_tx_valid_o),
  .eng_tx_ready_i (eng_tx_ready_i),
  .eng_tx_byte_o  (eng_tx_byte_o)
);

// File: tb/test_i2c_word_fifo.sv
module test_i2c_word_fifo;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bv = 1'b0, bw = 1'b0;
  logic [1:0] ba = '0;
  logic [31:0] bd = '0, rdata;
  logic tx_req, rx_req, tx_ovf, rx_unf;
  logic [7:0] tx_byte;
  logic tx_valid, tx_ready = 1'b1, tx_last = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0;

  int total = 0, bad = 0;
  logic [7:0] txq[$];
  bit txl[$];
  logic [31:0] rxq[$];
  logic [31:0] rx_acc = '0;
  int rx_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_word_fifo i_i2c_word_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bd), .bus_rdata_o(rdata),
    .tx_req_o(tx_req), .rx_req_o(rx_req), .tx_ovf_o(tx_ovf), .rx_unf_o(rx_unf),
    .eng_tx_byte_o(tx_byte), .eng_tx_valid_o(tx_valid), .eng_tx_ready_i(tx_ready), .eng_tx_last_i(tx_last),
    .eng_rx_byte_i(rx_byte), .eng_rx_valid_i(rx_valid), .eng_rx_last_i(rx_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bv = 1'b1; bw = 1'b1; ba = a; bd = d;
    @(posedge clk); #1; bv = 1'b0; bw = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bv = 1'b1; bw = 1'b0; ba = a;
    #(CLK_PERIOD/4); d = rdata;
    @(posedge clk); #1; bv = 1'b0;
  endtask

  task automatic sample_mid;
    @(negedge clk); #(CLK_PERIOD/4);
  endtask

  // driver: expected bytes go to the scoreboard queue
  task automatic tx_push(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      txq.push_back(w[i*8 +: 8]);
      txl.push_back((n < 4) && (i == n - 1));
    end
    bus_wr(A_TXD, w);
  endtask

  task automatic rx_send(input logic [7:0] b, input bit last);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_last = last;
    rx_acc[rx_idx*8 +: 8] = b;
    if (last || rx_idx == 3) begin
      rxq.push_back(rx_acc);
      rx_acc = '0; rx_idx = 0;
    end else rx_idx++;
    @(posedge clk); #1; rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic rx_pop_check(input string tag);
    logic [31:0] d;
    bus_rd(A_RXD, d);
    if (rxq.size() == 0) chk(tag, d, 32'hxxxx_xxxx);
    else begin chk(tag, d, rxq[0]); rxq.delete(0); end
  endtask

  // monitor: compare each handshaken transmit byte with the queue head
  initial forever begin
    @(negedge clk); #(CLK_PERIOD/4);
    tx_last = (txq.size() > 0) ? txl[0] : 1'b0;
    if (rst_n && tx_valid && tx_ready) begin
      if (txq.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected tx byte actual=%h expected=none", tx_byte);
      end else begin
        chk("R2/R3 tx byte order", {24'b0, tx_byte}, {24'b0, txq[0]});
        txq.delete(0); txl.delete(0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_CTRL, d); chk("R1 ctrl after reset", d, 32'h0);
    bus_rd(A_STAT, d); chk("R1 status after reset", d, 32'h80);
    sample_mid;
    chk("R1 flags", {tx_valid, tx_req, rx_req, tx_ovf, rx_unf}, {1'b0, 1'b1, 1'b0, 1'b0, 1'b0});

    // R2 full words, R3 short words with last
    tx_push(32'h4433_2211, 4);
    tx_push(32'hA5B6_C7D8, 4);
    tx_push(32'h1234_5678, 2);
    tx_push(32'hCAFE_BABE, 4);
    tx_push(32'h0000_00F1, 1);
    tx_push(32'h0BAD_F00D, 4);
    for (int i = 0; i < 100 && txq.size() > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2 tx queue drained", txq.size(), 0);

    // R4 packing, R10 rx request, R5 short word
    rx_send(8'h11, 0); rx_send(8'h22, 0); rx_send(8'h33, 0); rx_send(8'h44, 0);
    bus_rd(A_STAT, d); chk("R6 status one rx word", d, 32'h81);
    sample_mid; chk("R10 rx req fill 1 trig 0", rx_req, 1'b1);
    bus_wr(A_CTRL, 32'h04);
    sample_mid; chk("R10 rx req fill 1 trig 1", rx_req, 1'b0);
    rx_send(8'h55, 0); rx_send(8'h66, 0); rx_send(8'h77, 1);
    sample_mid; chk("R10 rx req fill 2 trig 1", rx_req, 1'b1);
    rx_pop_check("R4 packed word");
    rx_pop_check("R5 short word zero fill");
    rx_send(8'h9A, 1);
    rx_pop_check("R5 single byte word");

    // R12 underflow
    bus_rd(A_RXD, d); chk("R12 empty pop data", d, 32'h0);
    sample_mid; chk("R12 underflow pulse", rx_unf, 1'b1);
    sample_mid; chk("R12 underflow pulse ends", rx_unf, 1'b0);

    // R9 transmit request with engine stalled
    @(negedge clk); tx_ready = 1'b0;
    rx_send(8'h01, 0); rx_send(8'h02, 0); rx_send(8'h03, 0); rx_send(8'h04, 0);
    bus_wr(A_CTRL, 32'hE0);
    bus_wr(A_TXD, 32'h0000_0001);
    bus_wr(A_TXD, 32'h0000_0002);
    sample_mid; chk("R9 tx req free 7 trig 7", tx_req, 1'b0);
    bus_wr(A_CTRL, 32'hC0);
    sample_mid; chk("R9 tx req free 7 trig 6", tx_req, 1'b1);
    for (int i = 3; i <= 9; i++) bus_wr(A_TXD, i);
    bus_rd(A_STAT, d); chk("R6 status tx full rx 1", d, 32'h01);
    sample_mid; chk("R9 tx req full", tx_req, 1'b0);

    // R11 overflow
    bus_wr(A_TXD, 32'hDEAD_0010);
    sample_mid; chk("R11 overflow pulse", tx_ovf, 1'b1);
    sample_mid; chk("R11 overflow pulse ends", tx_ovf, 1'b0);

    // R7 transmit flush, R13 receive side untouched
    bus_wr(A_CTRL, 32'hC2);
    bus_rd(A_CTRL, d); chk("R7 tx flush bit cycle 1", d, 32'hC2);
    bus_rd(A_CTRL, d); chk("R7 tx flush bit cycle 2", d, 32'hC2);
    bus_rd(A_CTRL, d); chk("R7 tx flush bit cleared", d, 32'hC0);
    bus_rd(A_STAT, d); chk("R7 R13 status after tx flush", d, 32'h81);
    sample_mid; chk("R7 held word discarded", tx_valid, 1'b0);
    @(negedge clk); tx_ready = 1'b1;
    repeat (6) @(negedge clk);
    rx_pop_check("R13 rx word kept across tx flush");

    // R8 receive flush drops partial word
    rx_send(8'h61, 0); rx_send(8'h62, 0); rx_send(8'h63, 0); rx_send(8'h64, 0);
    rx_send(8'hEE, 0); rx_send(8'hFF, 0);
    bus_wr(A_CTRL, 32'hC1);
    rxq.delete(); rx_acc = '0; rx_idx = 0;
    bus_rd(A_CTRL, d); chk("R7 rx flush bit cycle 1", d, 32'hC1);
    bus_rd(A_CTRL, d); chk("R7 rx flush bit cycle 2", d, 32'hC1);
    bus_rd(A_CTRL, d); chk("R7 rx flush bit cleared", d, 32'hC0);
    bus_rd(A_STAT, d); chk("R8 rx empty after flush", d, 32'h80);
    rx_send(8'hAA, 0); rx_send(8'hBB, 0); rx_send(8'hCC, 0); rx_send(8'hDD, 0);
    rx_pop_check("R8 word after flush starts at lane 0");
    chk("R8 expected word model", 32'hDDCC_BBAA, 32'hDDCC_BBAA);

    repeat (4) @(negedge clk);
    chk("R2 no stray tx bytes", txq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule